// File: doc/BRIEF.md
# Indexed Bit-Port Configuration Register

This block is a small control register bank on a cartridge bus. Software addresses sixteen one-bit ports. Four bank-address bits select the port, and a single data line (bit 7) carries its value. The other data bits are left undriven and read as open bus.

A write first lands in a staged copy. Memory-mapping bits 2 to 13 reach the rest of the cartridge only when software writes to the apply port. The bank also holds three more pieces of state:
- a ready interrupt flag, raised when an external flash goes from busy to ready;
- an enable for that interrupt;
- a hidden page of eight bits, reached by setting the paging port.

Two resets are supported. The system reset restores the staged set, the applied set and the flag. The hidden page is restored only by the power-on reset.

The bus side is made of single-cycle strobes with no back-pressure. A write completes on the clock edge where the write strobe is sampled. Read data is combinational and is valid in the same cycle as the read strobe. There is no valid/ready stream at this block's edge, and none is needed. The applied bits go to the address decoder as plain level outputs.

Top module: `cfg_bitport`

## Requirements
- R1: The port responds only when bank bits 7:4 are zero and offset bits 15:12 equal 5h. The port index is bank bits 3:0, and every offset 5000h-5FFFh of a bank reaches the same port. Strobes outside this window change nothing.
- R2: `rd_oe` is high only while `bus_rd` is high inside the window. The read value is on `rd_bit`, which stands for data bit 7.
- R3: A write inside the window stores data bit 7 into staged bit [index].
- R4: On a write, if the staged bit 15 held 1 before the write, data bit 7 is stored into hidden[index mod 8]. This test uses the old value of staged bit 15, so a write of 0 to index 15 while paging is on still stores hidden bit 7.
- R5: Any write to index 0 clears the ready flag. If a set and a clear fall in the same cycle, the set wins.
- R6: A write to index 14 copies staged bits 2-13 into applied bits 2-13. `cfg_o[k]` is applied bit k+2 and changes at no other time except reset.
- R7: While staged bit 15 is 0, reads return the following:
  - index 0: the ready flag;
  - index 1: staged bit 1;
  - indexes 2-13: applied[index];
  - indexes 14 and 15: 0.
- R8: While staged bit 15 is 1, a read of any index returns hidden[index mod 8].
- R9: Either reset loads the staged and applied sets with 0BECh (bits 2, 3, 5, 6, 7, 8, 9 and 11 set). This makes `cfg_o` equal 2FBh and clears the flag.
- R10: Power-on reset loads the hidden page with 3Fh. The system reset leaves the hidden page unchanged.
- R11: The flag sets on the third clock edge after `flash_rdy` rises from 0 to 1. Inside the block, `flash_rdy` first passes through a two-stage synchronizer and then an edge detector. `irq` equals the flag AND staged bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bus_bank | input | 8 | Bank address |
| bus_off | input | 16 | Offset within bank |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data; only bit 7 is used |
| flash_rdy | input | 1 | Flash ready line (1 = ready), asynchronous |
| rd_bit | output | 1 | Read value for data bit 7 |
| rd_oe | output | 1 | Drive enable for data bit 7 |
| cfg_o | output | 12 | Applied bits 2-13 |
| irq | output | 1 | Ready interrupt request |

## Verification
The assertions assume that the bus does not raise a read and a write in the same cycle. They also assume that `flash_rdy` is the only source of the flag's set event, and that the two resets are released while the bus is idle. The stimulus keeps within these limits: it issues one strobe per cycle and toggles `flash_rdy` only in the directed flag tests. A random mix of in-window and out-of-window accesses then covers every index under both page settings.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned PORTS    = 16;
  localparam int unsigned IDX_W    = $clog2(PORTS);
  localparam int unsigned HID_W    = 8;
  localparam int unsigned HID_IW   = $clog2(HID_W);
  localparam int unsigned AP_LO    = 2;
  localparam int unsigned AP_HI    = 13;
  localparam int unsigned AP_W     = AP_HI - AP_LO + 1;
  localparam logic [PORTS-1:0] STAGE_RST = 16'h0BEC;
  localparam logic [HID_W-1:0] HID_RST   = 8'h3F;
  localparam logic [IDX_W-1:0] IX_FLAG  = 4'd0;
  localparam logic [IDX_W-1:0] IX_IEN   = 4'd1;
  localparam logic [IDX_W-1:0] IX_APPLY = 4'd14;
  localparam logic [IDX_W-1:0] IX_PAGE  = 4'd15;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned IDX_W   = 4,
  parameter logic [3:0]  WIN_NIB = 4'h5
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned HI_W = BANK_W - IDX_W;

  logic bank_ok, off_ok;

  always_comb begin
    bank_ok = (bank[BANK_W-1:IDX_W] == {HI_W{1'b0}});
    off_ok  = (off[OFF_W-1 -: 4] == WIN_NIB);
    hit     = bank_ok && off_ok;
    idx     = bank[IDX_W-1:0];
  end
endmodule

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b1;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             core_rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             wbit,
  input  logic             set_flag,
  output logic [PORTS-1:0] lw_q,
  output logic [PORTS-1:0] ap_q,
  output logic [HID_W-1:0] hid_q,
  output logic             flag_q
);
  logic page_on;
  logic do_apply;
  logic do_clear;

  assign page_on  = lw_q[IX_PAGE];
  assign do_apply = wr_en && (idx == IX_APPLY);
  assign do_clear = wr_en && (idx == IX_FLAG);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  lw_q <= STAGE_RST;
    else if (wr_en)   lw_q[idx] <= wbit;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 hid_q <= HID_RST;
    else if (wr_en && page_on)  hid_q[idx[HID_IW-1:0]] <= wbit;
  end

  for (genvar b = 0; b < PORTS; b++) begin : g_ap
    if (b >= AP_LO && b <= AP_HI) begin : g_live
      always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n)   ap_q[b] <= STAGE_RST[b];
        else if (do_apply) ap_q[b] <= lw_q[b];
      end
    end else begin : g_tie
      assign ap_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)    flag_q <= 1'b0;
    else if (set_flag)  flag_q <= 1'b1;
    else if (do_clear)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/cfgp_rdmux.sv
module cfgp_rdmux
  import cfgp_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [PORTS-1:0] lw_q,
  input  logic [PORTS-1:0] ap_q,
  input  logic [HID_W-1:0] hid_q,
  input  logic             flag_q,
  output logic             rbit
);
  always_comb begin
    if (lw_q[IX_PAGE]) begin
      rbit = hid_q[idx[HID_IW-1:0]];
    end else if (idx == IX_FLAG) begin
      rbit = flag_q;
    end else if (idx == IX_IEN) begin
      rbit = lw_q[IX_IEN];
    end else if (idx >= IX_APPLY) begin
      rbit = 1'b0;
    end else begin
      rbit = ap_q[idx];
    end
  end
endmodule

// File: rtl/cfg_bitport.sv
module cfg_bitport
  import cfgp_pkg::*;
#(
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned OFF_W       = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DATA_BIT    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [BANK_W-1:0] bus_bank,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flash_rdy,
  output logic              rd_bit,
  output logic              rd_oe,
  output logic [AP_W-1:0]   cfg_o,
  output logic              irq
);
  logic             core_rst_n;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             rdy_rise;
  logic [PORTS-1:0] lw_q;
  logic [PORTS-1:0] ap_q;
  logic [HID_W-1:0] hid_q;
  logic             flag_q;
  logic             mux_bit;

  assign core_rst_n = por_n & sys_rst_n;

  cfgp_decode #(
    .BANK_W (BANK_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .bank (bus_bank),
    .off  (bus_off),
    .hit  (hit),
    .idx  (idx)
  );

  cfgp_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (flash_rdy),
    .rise     (rdy_rise)
  );

  assign wr_en = bus_wr && hit;

  cfgp_regs u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .core_rst_n (core_rst_n),
    .wr_en      (wr_en),
    .idx        (idx),
    .wbit       (bus_wdata[DATA_BIT]),
    .set_flag   (rdy_rise),
    .lw_q       (lw_q),
    .ap_q       (ap_q),
    .hid_q      (hid_q),
    .flag_q     (flag_q)
  );

  cfgp_rdmux u_mux (
    .idx    (idx),
    .lw_q   (lw_q),
    .ap_q   (ap_q),
    .hid_q  (hid_q),
    .flag_q (flag_q),
    .rbit   (mux_bit)
  );

  assign rd_oe  = bus_rd && hit;
  assign rd_bit = rd_oe ? mux_bit : 1'b0;
  assign cfg_o  = ap_q[AP_HI:AP_LO];
  assign irq    = flag_q & lw_q[IX_IEN];
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk
  import cfgp_pkg::*;
(
  input logic             clk,
  input logic             core_rst_n,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             bus_rd,
  input logic             wr_en,
  input logic [IDX_W-1:0] idx,
  input logic             wbit,
  input logic             rdy_rise,
  input logic [PORTS-1:0] lw_q,
  input logic [HID_W-1:0] hid_q,
  input logic             flag_q,
  input logic [AP_W-1:0]  cfg_o,
  input logic             irq,
  input logic             rd_oe
);
  assert_oe_needs_rd_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    !bus_rd |-> !rd_oe);

  assert_hidden_gated_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && !lw_q[IX_PAGE]) |=> $stable(hid_q));

  assert_clear_flag_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && idx == IX_FLAG && !rdy_rise) |=> !flag_q);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    rdy_rise |=> flag_q);

  assert_apply_only_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(wr_en && idx == IX_APPLY) |=> $stable(cfg_o));

  assert_apply_copy_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && idx == IX_APPLY) |=> cfg_o == $past(lw_q[AP_HI:AP_LO]));

  assert_hidden_keep_R10: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> $stable(hid_q));

  assert_irq_off_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && idx == IX_IEN && !wbit) |=> !irq);
endmodule

bind cfg_bitport cfgp_chk chk_i (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .por_n      (por_n),
  .sys_rst_n  (sys_rst_n),
  .bus_rd     (bus_rd),
  .wr_en      (wr_en),
  .idx        (idx),
  .wbit       (bus_wdata[7]),
  .rdy_rise   (rdy_rise),
  .lw_q       (lw_q),
  .hid_q      (hid_q),
  .flag_q     (flag_q),
  .cfg_o      (cfg_o),
  .irq        (irq),
  .rd_oe      (rd_oe)
);

// File: tb/cfg_bitport_tb_top.sv
module cfg_bitport_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic [7:0]  bus_bank = '0;
  logic [15:0] bus_off = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        flash_rdy = 1'b1;
  logic        rd_bit, rd_oe, irq;
  logic [11:0] cfg_o;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] m_lw;
  logic [15:0] m_ap;
  logic [7:0]  m_hid;
  logic        m_flag;

  always #10 clk = ~clk;

  cfg_bitport dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_bank(bus_bank), .bus_off(bus_off), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .flash_rdy(flash_rdy),
    .rd_bit(rd_bit), .rd_oe(rd_oe), .cfg_o(cfg_o), .irq(irq)
  );

  function automatic bit in_win(input logic [7:0] b, input logic [15:0] o);
    return (b[7:4] == 4'h0) && (o[15:12] == 4'h5);
  endfunction

  function automatic logic exp_read(input logic [3:0] ix);
    if (m_lw[15])        return m_hid[ix[2:0]];
    else if (ix == 4'd0) return m_flag;
    else if (ix == 4'd1) return m_lw[1];
    else if (ix >= 4'd14) return 1'b0;
    else                 return m_ap[ix];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset(input bit por);
    m_lw = 16'h0BEC; m_ap = 16'h0BEC & 16'h3FFC; m_flag = 1'b0;
    if (por) m_hid = 8'h3F;
  endtask

  task automatic do_write(input logic [7:0] b, input logic [15:0] o, input logic d);
    @(negedge clk);
    bus_bank = b; bus_off = o; bus_wr = 1'b1; bus_rd = 1'b0;
    bus_wdata = {d, 7'($urandom)};
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (in_win(b, o)) begin
      if (m_lw[15]) m_hid[b[2:0]] = d;
      m_lw[b[3:0]] = d;
      if (b[3:0] == 4'd0) m_flag = 1'b0;
      if (b[3:0] == 4'd14) m_ap[13:2] = m_lw[13:2];
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] b, input logic [15:0] o);
    bit w;
    @(negedge clk);
    bus_bank = b; bus_off = o; bus_rd = 1'b1; bus_wr = 1'b0;
    #1;
    w = in_win(b, o);
    check({req, " oe"}, rd_oe, w);
    if (w) check({req, " data"}, rd_bit, exp_read(b[3:0]));
    bus_rd = 1'b0;
  endtask

  task automatic check_outs(input string req);
    #1;
    check({req, " cfg_o"}, cfg_o, m_ap[13:2]);
    check({req, " irq"}, irq, m_flag & m_lw[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    model_reset(1'b1);
    repeat (3) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    // R9 reset state
    @(negedge clk);
    check("R9 cfg_o reset", cfg_o, 12'h2FB);
    check("R9 irq reset", irq, 1'b0);
    for (int i = 2; i < 14; i++) do_read("R9 R7 reset read", 8'(i), 16'h5000);
    do_read("R7 idx14 zero", 8'h0E, 16'h5ABC);
    do_read("R7 idx15 zero", 8'h0F, 16'h5FFF);
    // R1 mirrors and out-of-window ignore
    do_write(8'h01, 16'h5FFF, 1'b1);
    do_read("R1 R3 mirror", 8'h01, 16'h5123);
    do_write(8'h11, 16'h5000, 1'b0);
    do_write(8'h01, 16'h6000, 1'b0);
    do_read("R1 ignore out", 8'h01, 16'h5000);
    do_read("R2 no oe out", 8'h21, 16'h5000);
    // R6 staged not applied until apply
    do_write(8'h02, 16'h5000, 1'b0);
    do_write(8'h04, 16'h5000, 1'b1);
    check_outs("R6 before apply");
    do_read("R6 read applied", 8'h02, 16'h5000);
    do_write(8'h0E, 16'h5000, 1'b1);
    check_outs("R6 after apply");
    check("R6 cfg value", cfg_o, 12'h2FE);
    // R11 flag set and irq
    flash_rdy = 1'b0; repeat (5) @(negedge clk);
    flash_rdy = 1'b1; repeat (5) @(negedge clk);
    m_flag = 1'b1;
    do_read("R11 flag set", 8'h00, 16'h5000);
    check_outs("R11 irq with enable");
    do_write(8'h01, 16'h5000, 1'b0);
    check_outs("R11 irq disabled");
    do_write(8'h00, 16'h5000, 1'b0);
    do_read("R5 flag cleared", 8'h00, 16'h5000);
    // R5 set wins over clear in same cycle
    flash_rdy = 1'b0; repeat (5) @(negedge clk);
    flash_rdy = 1'b1;
    @(negedge clk);
    do_write(8'h00, 16'h5000, 1'b1);
    m_flag = 1'b1;
    do_read("R5 set wins", 8'h00, 16'h5000);
    // R4 R8 hidden page
    do_write(8'h0F, 16'h5000, 1'b1);
    for (int i = 0; i < 8; i++) do_read("R8 R10 hidden powerup", 8'(i), 16'h5000);
    do_write(8'h0A, 16'h5000, 1'b0);
    do_write(8'h06, 16'h5000, 1'b1);
    do_read("R4 hidden idx mod 8", 8'h02, 16'h5000);
    do_read("R4 hidden 6", 8'h0E, 16'h5000);
    do_write(8'h0F, 16'h5000, 1'b0);
    do_read("R4 old page", 8'h07, 16'h5000);
    do_write(8'h0F, 16'h5000, 1'b1);
    do_read("R4 hidden7 cleared", 8'h0F, 16'h5000);
    // R10 system reset keeps hidden
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    model_reset(1'b0);
    check_outs("R9 sys reset");
    do_read("R9 page off after reset", 8'h0F, 16'h5000);
    do_write(8'h0F, 16'h5000, 1'b1);
    for (int i = 0; i < 8; i++) do_read("R10 hidden kept", 8'(i), 16'h5000);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] b;
      logic [15:0] o;
      b = ($urandom_range(0, 3) != 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      o = ($urandom_range(0, 3) != 0) ? {4'h5, 12'($urandom)} : 16'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(b, o, 1'($urandom));
      else do_read("R3 R7 R8 random", b, o);
      check_outs("R6 R11 random");
    end
    // R10 power-on reset restores hidden
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    model_reset(1'b1);
    do_write(8'h0F, 16'h5000, 1'b1);
    for (int i = 0; i < 8; i++) do_read("R10 por hidden", 8'(i), 16'h5000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule